// File: doc/BRIEF.md
# TDC Step-Size Calibrator (sign-sign LMS)

This block holds the step size of a time-to-digital converter at a fixed target while process, supply and temperature drift. It drives a tuning word that sets how many load capacitors hang on the converter's delay inverters. Once the PLL is locked, each reference cycle delivers one phase-error sample with the predicted fine fractional phase. The block moves the tuning word one LSB per update, in the direction given by the product of the two signs. It needs no separate timing reference: the ripple of the loop's own phase error is the error signal.

The calibrator counts how often the word changes direction. When the word has turned back and forth often enough within a window of updates, it is taken as settled and `done` is raised. Depending on `bg_mode`, the word is then either frozen, which saves power, or kept adapting at a decimated rate of one update per 2^`dec_exp` samples. From the frozen state a programmable cycle timer can restart a full adaptation. Losing lock or dropping `cal_en` stops all updates and keeps the word.

Samples arrive on a valid/ready stream. `s_ready` is always high, so the block never applies back-pressure. A sample offered while the block is not adapting is accepted and discarded. Control and status pins are plain levels.

Top module: `tdc_step_cal`

## Requirements
- R1: After reset `tw` equals the `TW_RESET` parameter (32 by default), `done` is 0 and the block is idle.
- R2: No sample changes `tw` while `cal_en` is 0 or while the block waits for `pll_locked`. Adaptation begins on the second clock edge after `cal_en` and `pll_locked` are both high.
- R3: In adaptation each accepted sample moves `tw` by exactly one LSB. It increments when `s_phe` > 0 with `s_frac` >= 2^(FRAC_W-1), or when `s_phe` < 0 with `s_frac` < 2^(FRAC_W-1). It decrements for the other two sign combinations, and holds when `s_phe` is 0. `s_phe` is two's complement.
- R4: `tw` saturates at 0 and at 2^TW_W-1; a step beyond either limit leaves it unchanged.
- R5: A reversal is a non-zero step opposite to the previous non-zero step within the current window. When the REV_MIN-th reversal (8) occurs within WIN (64) adaptation samples, `done` rises on that same edge. The window restarts after its WIN-th sample, and its reversal count and direction history are cleared then.
- R6: With `bg_mode` = 0 the block freezes after settling: `tw` ignores every sample and `done` stays 1.
- R7: With `bg_mode` = 1 the block continues after settling, applying the R3 rule only on every 2^`dec_exp`-th accepted sample, counted from entry into background mode.
- R8: While frozen with `rerun_cycles` = P (non-zero), the block returns to adaptation and drops `done` on the P-th clock edge counted from when P is set or the freeze began. P = 0 disables the rerun.
- R9: Dropping `pll_locked` in any active state returns the block to waiting for lock on the next edge, clears `done` and keeps `tw`.
- R10: `s_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_en | input | 1 | Calibration enable |
| pll_locked | input | 1 | PLL lock indication |
| bg_mode | input | 1 | 1: background adaptation after settling, 0: freeze |
| dec_exp | input | DEC_W (4) | Background decimation exponent N, one update per 2^N samples |
| rerun_cycles | input | TMR_W (16) | Cycles spent frozen before a rerun, 0 disables |
| s_valid | input | 1 | Phase-error sample valid |
| s_ready | output | 1 | Sample ready, constant 1 |
| s_phe | input | PHE_W (12) | Signed phase error |
| s_frac | input | FRAC_W (8) | Predicted fractional phase, unsigned fraction of a cycle |
| tw | output | TW_W (6) | TDC tuning word |
| done | output | 1 | Calibration settled (settled, background or frozen) |

## Verification
The bench builds the block with its default parameters: a 6-bit word, a 64-sample window and 8 reversals. With these values both saturation limits can be reached within a few dozen samples. A run of updates crosses a window boundary just before an alternating run. If the window did not clear its history, that run would settle one sample early, so the restart is observable from `done`. A decimation exponent of 2 and a rerun interval of 12 make the background spacing and the exact rerun edge cheap to count.

// File: rtl/tdc_cal_pkg.sv
package tdc_cal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT_LOCK, ST_ADAPT, ST_SETTLED, ST_BACKGROUND, ST_FROZEN
  } cal_state_e;

  typedef enum logic [1:0] {
    STEP_HOLD, STEP_UP, STEP_DOWN
  } step_e;
endpackage

// File: rtl/tdc_cal_sign_step.sv
module tdc_cal_sign_step
  import tdc_cal_pkg::*;
#(
  parameter int PHE_W  = 12,
  parameter int FRAC_W = 8
) (
  input  logic signed [PHE_W-1:0] phe,
  input  logic [FRAC_W-1:0]       frac,
  output step_e                   step
);
  localparam logic [FRAC_W-1:0] HALF = FRAC_W'(1) << (FRAC_W - 1);

  logic phe_zero, phe_neg, frac_hi;

  always_comb begin
    phe_zero = (phe == '0);
    phe_neg  = phe[PHE_W-1];
    frac_hi  = (frac >= HALF);
    if (phe_zero)               step = STEP_HOLD;
    else if (phe_neg ^ frac_hi) step = STEP_UP;
    else                        step = STEP_DOWN;
  end
endmodule

// File: rtl/tdc_cal_word.sv
module tdc_cal_word
  import tdc_cal_pkg::*;
#(
  parameter int TW_W     = 6,
  parameter int TW_RESET = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            apply,
  input  step_e           step,
  output logic [TW_W-1:0] tw
);
  localparam logic [TW_W-1:0] TW_MAX  = {TW_W{1'b1}};
  localparam logic [TW_W-1:0] TW_INIT = TW_W'(TW_RESET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tw <= TW_INIT;
    end else if (apply) begin
      if (step == STEP_UP && tw != TW_MAX)        tw <= tw + 1'b1;
      else if (step == STEP_DOWN && tw != '0)     tw <= tw - 1'b1;
    end
  end

  AST_TW_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tw == $past(tw)) || (tw == $past(tw) + 1'b1) || (tw == $past(tw) - 1'b1)); // R3

  AST_TW_HOLD_NO_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(tw)); // R2
endmodule

// File: rtl/tdc_cal_conv.sv
module tdc_cal_conv
  import tdc_cal_pkg::*;
#(
  parameter int WIN     = 64,
  parameter int REV_MIN = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clear,
  input  logic  apply,
  input  step_e step,
  output logic  hit
);
  localparam int WIN_W = $clog2(WIN);
  localparam int REV_W = $clog2(REV_MIN + 1);

  logic [WIN_W-1:0] win_cnt;
  logic [REV_W-1:0] rev_cnt, rev_next;
  step_e            last_dir;
  logic             is_rev, win_end;

  always_comb begin
    is_rev   = apply && (step != STEP_HOLD) && (last_dir != STEP_HOLD) && (step != last_dir);
    rev_next = rev_cnt + REV_W'(is_rev);
    hit      = apply && (rev_next >= REV_W'(REV_MIN));
    win_end  = apply && (win_cnt == WIN_W'(WIN - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt  <= '0;
      rev_cnt  <= '0;
      last_dir <= STEP_HOLD;
    end else if (clear || hit || win_end) begin
      win_cnt  <= '0;
      rev_cnt  <= '0;
      last_dir <= STEP_HOLD;
    end else if (apply) begin
      win_cnt <= win_cnt + 1'b1;
      rev_cnt <= rev_next;
      if (step != STEP_HOLD) last_dir <= step;
    end
  end

  AST_REV_WITHIN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    REV_W'(rev_cnt) <= REV_W'(win_cnt) || win_cnt >= WIN_W'(REV_MIN)); // R5
endmodule

// File: rtl/tdc_cal_rate.sv
module tdc_cal_rate #(
  parameter int DEC_W = 4,
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bg_active,
  input  logic             frozen_active,
  input  logic             sample,
  input  logic [DEC_W-1:0] dec_exp,
  input  logic [TMR_W-1:0] rerun_cycles,
  output logic             bg_tick,
  output logic             rerun_fire
);
  localparam int DCNT_W = (1 << DEC_W) - 1;

  logic [DCNT_W-1:0] dcnt, mask;
  logic [TMR_W-1:0]  tmr;
  logic              tmr_run;

  always_comb begin
    mask       = (DCNT_W'(1) << dec_exp) - DCNT_W'(1);
    bg_tick    = bg_active && sample && ((dcnt & mask) == mask);
    tmr_run    = frozen_active && (rerun_cycles != '0);
    rerun_fire = tmr_run && (tmr == rerun_cycles - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          dcnt <= '0;
    else if (!bg_active) dcnt <= '0;
    else if (sample)     dcnt <= dcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tmr <= '0;
    else if (!tmr_run) tmr <= '0;
    else               tmr <= tmr + 1'b1;
  end

  AST_BG_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (bg_tick && dec_exp != '0) |=> (!bg_tick || dec_exp == '0)); // R7

  AST_RERUN_NEEDS_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
    rerun_fire |-> $past(frozen_active)); // R8
endmodule

// File: rtl/tdc_step_cal.sv
module tdc_step_cal
  import tdc_cal_pkg::*;
#(
  parameter int PHE_W    = 12,
  parameter int FRAC_W   = 8,
  parameter int TW_W     = 6,
  parameter int TW_RESET = 32,
  parameter int WIN      = 64,
  parameter int REV_MIN  = 8,
  parameter int DEC_W    = 4,
  parameter int TMR_W    = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cal_en,
  input  logic                    pll_locked,
  input  logic                    bg_mode,
  input  logic [DEC_W-1:0]        dec_exp,
  input  logic [TMR_W-1:0]        rerun_cycles,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic signed [PHE_W-1:0] s_phe,
  input  logic [FRAC_W-1:0]       s_frac,
  output logic [TW_W-1:0]         tw,
  output logic                    done
);
  cal_state_e state, nxt;
  step_e      step;
  logic       apply, in_adapt, bg_tick, rerun_fire, conv_hit;

  assign s_ready  = 1'b1;
  assign in_adapt = (state == ST_ADAPT);
  assign apply    = (in_adapt && s_valid) || bg_tick;
  assign done     = (state == ST_SETTLED) || (state == ST_BACKGROUND) || (state == ST_FROZEN);

  tdc_cal_sign_step #(.PHE_W(PHE_W), .FRAC_W(FRAC_W)) u_sign (
    .phe(s_phe), .frac(s_frac), .step(step)
  );

  tdc_cal_word #(.TW_W(TW_W), .TW_RESET(TW_RESET)) u_word (
    .clk(clk), .rst_n(rst_n), .apply(apply), .step(step), .tw(tw)
  );

  tdc_cal_conv #(.WIN(WIN), .REV_MIN(REV_MIN)) u_conv (
    .clk(clk), .rst_n(rst_n), .clear(!in_adapt), .apply(in_adapt && s_valid),
    .step(step), .hit(conv_hit)
  );

  tdc_cal_rate #(.DEC_W(DEC_W), .TMR_W(TMR_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .bg_active(state == ST_BACKGROUND),
    .frozen_active(state == ST_FROZEN), .sample(s_valid), .dec_exp(dec_exp),
    .rerun_cycles(rerun_cycles), .bg_tick(bg_tick), .rerun_fire(rerun_fire)
  );

  always_comb begin
    nxt = state;
    if (!cal_en) begin
      nxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:      nxt = ST_WAIT_LOCK;
        ST_WAIT_LOCK: if (pll_locked) nxt = ST_ADAPT;
        default: begin
          if (!pll_locked) nxt = ST_WAIT_LOCK;
          else begin
            unique case (state)
              ST_ADAPT:   if (conv_hit) nxt = ST_SETTLED;
              ST_SETTLED: nxt = bg_mode ? ST_BACKGROUND : ST_FROZEN;
              ST_FROZEN:  if (rerun_fire) nxt = ST_ADAPT;
              default:    nxt = state;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  AST_WAIT_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_LOCK) |=> $stable(tw)); // R2

  AST_DONE_FROM_ADAPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(state) == ST_ADAPT); // R5

  AST_FROZEN_HOLDS_TW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FROZEN && $past(state) == ST_FROZEN) |-> $stable(tw)); // R6

  AST_LOCK_LOSS_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_en && !pll_locked && state != ST_IDLE) |=> state == ST_WAIT_LOCK); // R9
endmodule

// File: tb/tdc_step_cal_tb.sv
module tdc_step_cal_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_en = 1'b0, pll_locked = 1'b0, bg_mode = 1'b0;
  logic [3:0] dec_exp = '0;
  logic [15:0] rerun_cycles = '0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic signed [11:0] s_phe = '0;
  logic [7:0] s_frac = '0;
  logic [5:0] tw;
  logic done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  tdc_step_cal u_dut (
    .clk(clk), .rst_n(rst_n), .cal_en(cal_en), .pll_locked(pll_locked),
    .bg_mode(bg_mode), .dec_exp(dec_exp), .rerun_cycles(rerun_cycles),
    .s_valid(s_valid), .s_ready(s_ready), .s_phe(s_phe), .s_frac(s_frac),
    .tw(tw), .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // n samples of the same kind; fhi selects s_frac above or below half
  task automatic send(input int n, input int phe, input bit fhi);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_valid = 1'b1;
      s_phe   = 12'(phe);
      s_frac  = fhi ? 8'hC0 : 8'h40;
    end
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  // alternating steps with s_frac above half: +phe -> up, -phe -> down
  task automatic send_alt(input int n, input bit first_up);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_valid = 1'b1;
      s_frac  = 8'hC0;
      s_phe   = ((i % 2 == 0) == first_up) ? 12'sd5 : -12'sd5;
    end
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic t_reset;
    idle(2);
    chk("R1 tw", tw, 32);
    chk("R1 done", done, 0);
    chk("R10 ready", s_ready, 1);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic t_disabled;
    send(5, 7, 1'b1);
    chk("R2 disabled tw", tw, 32);
    cal_en = 1'b1;
    idle(2);
    send(5, 7, 1'b1);
    chk("R2 unlocked tw", tw, 32);
    chk("R2 unlocked done", done, 0);
  endtask

  task automatic t_rule;
    pll_locked = 1'b1;
    idle(2);
    send(1, 5, 1'b1);  chk("R3 pos/hi up", tw, 33);
    send(1, -3, 1'b1); chk("R3 neg/hi down", tw, 32);
    send(1, 0, 1'b1);  chk("R3 zero hold", tw, 32);
    send(1, 5, 1'b0);  chk("R3 pos/lo down", tw, 31);
    send(1, -5, 1'b0); chk("R3 neg/lo up", tw, 32);
    send(1, 5, 1'b0);  chk("R3 pos/lo down again", tw, 31);
  endtask

  // 6 samples used so far in this window, 3 reversals
  task automatic t_clamp_window;
    send(40, 5, 1'b1);
    chk("R4 upper clamp", tw, 63);
    send(18, 5, 1'b1);           // 64th window sample: window restarts
    chk("R5 no early done", done, 0);
    send_alt(8, 1'b0);           // 7 reversals in fresh window
    chk("R5 seven reversals not settled", done, 0);
    chk("R5 tw dither", tw, 63);
    send_alt(1, 1'b0);           // 8th reversal
    chk("R5 settled on 8th reversal", done, 1);
    chk("R5 tw after settle", tw, 62);
  endtask

  task automatic t_frozen;
    idle(1);
    send(20, 5, 1'b1);
    chk("R6 frozen tw", tw, 62);
    chk("R6 frozen done", done, 1);
  endtask

  task automatic t_rerun;
    rerun_cycles = 16'd12;
    idle(11);
    chk("R8 still frozen at edge 11", done, 1);
    idle(1);
    chk("R8 rerun at edge 12", done, 0);
    rerun_cycles = 16'd0;
  endtask

  task automatic t_background;
    bg_mode = 1'b1;
    dec_exp = 4'd2;
    send_alt(9, 1'b0);
    chk("R5 resettled", done, 1);
    chk("R5 tw", tw, 61);
    idle(1);
    send(3, 5, 1'b1);
    chk("R7 no update before 4th", tw, 61);
    send(1, 5, 1'b1);
    chk("R7 update on 4th", tw, 62);
    send(4, 5, 1'b1);
    chk("R7 update on 8th", tw, 63);
    chk("R10 ready in background", s_ready, 1);
  endtask

  task automatic t_lock_loss;
    pll_locked = 1'b0;
    idle(1);
    chk("R9 done cleared", done, 0);
    chk("R9 tw kept", tw, 63);
    send(5, -5, 1'b1);
    chk("R9 no update while unlocked", tw, 63);
    pll_locked = 1'b1;
    idle(2);
    send(70, -5, 1'b1);
    chk("R4 lower clamp", tw, 0);
    chk("R4 not settled", done, 0);
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_rule();
    t_clamp_window();
    t_frozen();
    t_rerun();
    t_background();
    t_lock_loss();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule